// File: doc/BRIEF.md
# Three-Channel Interval Timer

A byte-wide register block with three independent down-counting channels. Each channel has its own gate input. A shared one-cycle tick enable paces all of them. Addresses 0 to 2 reach the data ports of channels 0 to 2, and address 3 is the control port. A control byte picks a channel, an access scheme for the data port and an operating mode. Count values then arrive as one or two byte writes, and the current count can be snapshotted and read back byte by byte.

Each channel drives a waveform output whose shape depends on the mode, and an event pulse on every rising edge of that waveform. The event pulse of channel 0 is also brought out as the interrupt request. The design offers one-shot, periodic-rate and square-wave behaviour. A loaded count takes effect at once, and a stored count of zero stands for 65536 ticks.

Top module: `interval_timer`

## Requirements
- R1: A control byte is written to address 3. Bit 0 is accepted and has no effect. Bits 3:1 hold the mode, bits 5:4 the access scheme and bits 7:6 the channel. Addresses 0 to 2 are the channel data ports, and a read of address 3 returns 0.
- R2: After reset every channel is in mode 3 with a count of 65536 and two-byte access. All outputs are low and no event pulses occur until ticks arrive.
- R3: With access 1 a data write loads only the low byte, with the high byte zero. With access 2 it loads only the high byte, with the low byte zero. With access 1 a read returns the low byte of the count, and with access 2 it returns the high byte.
- R4: With access 3 the first data write only stores the low byte and leaves the running count untouched. The second write joins the high byte to it and commits. Reads under access 3 also alternate, low byte first.
- R5: A committed count of 0 runs as 65536, so one tick after loading zero the count reads 0xFFFF.
- R6: Every committed count restarts the channel from the new value in the cycle after the write.
- R7: A channel's count moves only in cycles where tick_i and that channel's gate are both high.
- R8: In mode 2 (and 6) the count reloads after N ticks, giving exactly one event pulse per N ticks.
- R9: In mode 3 (and 7) the output is a square wave. It goes high when the count falls to N-N/2 and low when the count reloads. Event pulses fall at ticks N/2, N/2+N, and so on after loading.
- R10: In modes 0, 4 and 5 exactly one event pulse occurs, on the N-th tick, and the count then stays at 0. In mode 0 the output stays low until that tick and high afterwards.
- R11: Mode 1 never produces an event pulse.
- R12: Access value 0 is a latch command. It freezes the current count for the next read sequence and changes neither the mode nor the access scheme.
- R13: An event pulse lasts one cycle, in the cycle after the causing tick. irq_o carries the pulse of channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0-2 channel data, 3 control |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe; advances read sequencing |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tick_i | input | 1 | One-cycle counting enable |
| gate_i | input | NUM_CH | Per-channel count enable |
| out_o | output | NUM_CH | Per-channel waveform output |
| edge_o | output | NUM_CH | Per-channel rising-edge event pulse |
| irq_o | output | 1 | Interrupt request (channel 0 event) |

## Verification
The bench builds the block with its defaults: three channels and 16-bit counts. Small loaded counts of 2 to 100 bring reloads, square-wave phase points and one-shot terminals within a few dozen ticks. The 65536 case is reached by loading zero and reading the count back after one tick. Channel 2 has its gate held low, which makes the gate dependency visible against channels 0 and 1.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  localparam logic [2:0] MODE_RST = 3'd3;

  // modes 6 and 7 alias 2 and 3
  function automatic logic [2:0] eff_mode(input logic [2:0] m);
    return (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
#(
  parameter  int CW = CNT_W,
  localparam int NW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic [2:0]    mode_i,
  input  logic          load_i,
  input  logic [NW-1:0] load_val_i,
  output logic [NW-1:0] cnt_o,
  output logic          out_o,
  output logic          edge_o
);
  localparam logic [NW-1:0] CNT_MAX = NW'(1) << CW;

  logic [NW-1:0] cnt_q, reload_q, cnt_nxt, half_v;
  logic [2:0]    m;
  logic          run, at_one, fire, edge_q;

  assign m      = eff_mode(mode_i);
  assign run    = tick_i & gate_i;
  assign at_one = (cnt_q == NW'(1));
  assign half_v = reload_q - (reload_q >> 1);

  always_comb begin
    if (cnt_q == '0)      cnt_nxt = '0;
    else if (at_one)      cnt_nxt = (m == 3'd2 || m == 3'd3) ? reload_q : '0;
    else                  cnt_nxt = cnt_q - NW'(1);
  end

  always_comb begin
    case (m)
      3'd0, 3'd4, 3'd5: begin
        fire  = run & at_one;
        out_o = (m == 3'd0) ? (cnt_q == '0) : !at_one;
      end
      3'd1: begin
        fire  = 1'b0;
        out_o = 1'b1;
      end
      3'd2: begin
        fire  = run & at_one;
        out_o = !at_one;
      end
      default: begin
        fire  = run && (cnt_q != '0) && (cnt_nxt == half_v);
        out_o = (cnt_q != '0) && (cnt_q <= half_v);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_MAX;
      reload_q <= CNT_MAX;
      edge_q   <= 1'b0;
    end else begin
      edge_q <= fire & ~load_i;
      if (load_i) begin
        cnt_q    <= load_val_i;
        reload_q <= load_val_i;
      end else if (run) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign edge_o = edge_q;

  AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(tick_i && gate_i)) |=> $stable(cnt_q)); // R7
  AST_MODE1_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_mode(mode_i) == 3'd1) |=> !edge_o); // R11
  AST_SPENT_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0)); // R10
  always_comb begin
    if (rst_ni) AST_CNT_BOUND: assert (cnt_q <= CNT_MAX); // R5
  end
endmodule

// File: rtl/pit_access.sv
module pit_access
  import pit_pkg::*;
#(
  parameter  int CW = CNT_W,
  localparam int NW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [4:0]    ctl_i,      // {access[1:0], mode[2:0]}
  input  logic          data_we_i,
  input  logic          data_re_i,
  input  logic [7:0]    wdata_i,
  input  logic [NW-1:0] cnt_i,
  output logic          load_o,
  output logic [NW-1:0] load_val_o,
  output logic [2:0]    mode_o,
  output logic [7:0]    rdata_o
);
  acc_e        acc_q, ctl_acc;
  logic [2:0]  mode_q;
  logic [7:0]  lo_q;
  logic        wr_hi_q, rd_hi_q, lat_vld_q;
  logic [CW-1:0] lat_q, raw, src;
  logic        sel_hi;

  assign ctl_acc = acc_e'(ctl_i[4:3]);

  always_comb begin
    case (acc_q)
      ACC_LO:  raw = {8'h00, wdata_i};
      ACC_HI:  raw = {wdata_i, 8'h00};
      default: raw = {wdata_i, lo_q};
    endcase
  end

  assign load_o     = data_we_i && (acc_q != ACC_LOHI || wr_hi_q);
  assign load_val_o = (raw == '0) ? (NW'(1) << CW) : {1'b0, raw};

  assign src     = lat_vld_q ? lat_q : (cnt_i[CW] ? '0 : cnt_i[CW-1:0]);
  assign sel_hi  = (acc_q == ACC_HI) || (acc_q == ACC_LOHI && rd_hi_q);
  assign rdata_o = sel_hi ? src[15:8] : src[7:0];
  assign mode_o  = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= ACC_LOHI;
      mode_q    <= MODE_RST;
      lo_q      <= '0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      lat_vld_q <= 1'b0;
      lat_q     <= '0;
    end else if (ctl_we_i) begin
      if (ctl_acc == ACC_LATCH) begin
        if (!lat_vld_q) begin
          lat_q     <= src;
          lat_vld_q <= 1'b1;
          rd_hi_q   <= 1'b0;
        end
      end else begin
        acc_q     <= ctl_acc;
        mode_q    <= ctl_i[2:0];
        wr_hi_q   <= 1'b0;
        rd_hi_q   <= 1'b0;
        lat_vld_q <= 1'b0;
      end
    end else begin
      if (data_we_i && acc_q == ACC_LOHI) begin
        wr_hi_q <= ~wr_hi_q;
        if (!wr_hi_q) lo_q <= wdata_i;
      end
      if (data_re_i) begin
        if (acc_q == ACC_LOHI) rd_hi_q <= ~rd_hi_q;
        if (acc_q != ACC_LOHI || rd_hi_q) lat_vld_q <= 1'b0;
      end
    end
  end

  AST_WIDE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (load_val_o != '0)); // R5
  AST_LOHI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !ctl_we_i && acc_q == ACC_LOHI && !wr_hi_q) |=> wr_hi_q); // R4
  AST_LATCH_KEEPS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_acc == ACC_LATCH) |=> $stable(mode_q) && $stable(acc_q)); // R12
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  input  logic [NUM_CH-1:0] gate_i,
  output logic [NUM_CH-1:0] out_o,
  output logic [NUM_CH-1:0] edge_o,
  output logic              irq_o
);
  localparam int         NW       = CNT_W + 1;
  localparam logic [1:0] CTL_ADDR = 2'd3;

  logic [7:0] ch_rd [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic          ctl_we, data_we, data_re, load;
    logic [NW-1:0] load_val, cnt;
    logic [2:0]    mode;

    assign ctl_we  = wr_en_i && addr_i == CTL_ADDR && wdata_i[7:6] == 2'(c);
    assign data_we = wr_en_i && addr_i == 2'(c);
    assign data_re = rd_en_i && addr_i == 2'(c);

    pit_access #(.CW(CNT_W)) i_access (
      .clk_i, .rst_ni,
      .ctl_we_i   (ctl_we),
      .ctl_i      (wdata_i[5:1]),
      .data_we_i  (data_we),
      .data_re_i  (data_re),
      .wdata_i,
      .cnt_i      (cnt),
      .load_o     (load),
      .load_val_o (load_val),
      .mode_o     (mode),
      .rdata_o    (ch_rd[c])
    );

    pit_count_core #(.CW(CNT_W)) i_core (
      .clk_i, .rst_ni,
      .tick_i,
      .gate_i     (gate_i[c]),
      .mode_i     (mode),
      .load_i     (load),
      .load_val_i (load_val),
      .cnt_o      (cnt),
      .out_o      (out_o[c]),
      .edge_o     (edge_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == 2'(c)) rdata_o = ch_rd[c];
  end

  assign irq_o = edge_o[0];
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] gate = 3'b011, out, edges;
  logic       irq;
  int n_chk = 0, n_fail = 0;
  int ecnt[3];
  int icnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer i_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .gate_i(gate),
    .out_o(out), .edge_o(edges), .irq_o(irq)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) if (edges[i]) ecnt[i]++;
    if (irq) icnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 3; i++) ecnt[i] = 0;
    icnt = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] a, output int v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] b; int v;
    idle(3);
    chk("R2 outputs low", int'(out), 0);
    chk("R2 no pulses", ecnt[0] + ecnt[1] + ecnt[2], 0);
    rd16(2'd0, v);
    chk("R2 reset count low16", v, 0);
    ticks(1);
    rd16(2'd0, v);
    chk("R2 count after one tick", v, 16'hFFFF);
    rd(2'd3, b);
    chk("R1 control read zero", int'(b), 0);
  endtask

  task automatic t_mode2();
    wr(2'd3, 8'h34); wr(2'd0, 8'd5); wr(2'd0, 8'd0);
    ticks(4);
    chk("R13 no pulse before Nth tick", int'(irq), 0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; #1;
    chk("R13 irq pulse after tick", int'(irq), 1);
    chk("R13 edge ch0 pulse", int'(edges[0]), 1);
    @(negedge clk); #1;
    chk("R13 pulse one cycle", int'(irq), 0);
    clr();
    ticks(15); idle(1);
    chk("R8 three periods", ecnt[0], 3);
    chk("R13 irq count", icnt, 3);
  endtask

  task automatic t_mode3();
    wr(2'd3, 8'h76); wr(2'd1, 8'd4); wr(2'd1, 8'd0);
    chk("R9 out low after load", int'(out[1]), 0);
    clr();
    ticks(2); idle(1);
    chk("R9 out high at N/2", int'(out[1]), 1);
    chk("R9 first edge at N/2", ecnt[1], 1);
    ticks(2);
    chk("R9 out low at reload", int'(out[1]), 0);
    ticks(6); idle(1);
    chk("R9 edges over 10 ticks", ecnt[1], 3);
    wr(2'd1, 8'd5); wr(2'd1, 8'd0);
    clr();
    ticks(6); idle(1);
    chk("R9 odd N first period", ecnt[1], 1);
    ticks(1); idle(1);
    chk("R9 odd N second edge", ecnt[1], 2);
  endtask

  task automatic t_oneshot(input int mode);
    wr(2'd3, 8'(8'h30 | (mode << 1))); wr(2'd0, 8'd3); wr(2'd0, 8'd0);
    clr();
    ticks(2); idle(1);
    chk("R10 no edge before N", ecnt[0], 0);
    if (mode == 0) chk("R10 mode0 out low", int'(out[0]), 0);
    ticks(1); idle(1);
    chk("R10 edge at N", ecnt[0], 1);
    if (mode == 0) chk("R10 mode0 out high", int'(out[0]), 1);
    ticks(10); idle(1);
    chk("R10 single edge", ecnt[0], 1);
    if (mode == 0) chk("R10 mode0 out stays", int'(out[0]), 1);
  endtask

  task automatic t_mode1();
    wr(2'd3, 8'h32); wr(2'd0, 8'd3); wr(2'd0, 8'd0);
    clr();
    ticks(10); idle(1);
    chk("R11 mode1 no edge", ecnt[0], 0);
  endtask

  task automatic t_gate();
    int v;
    wr(2'd3, 8'hB4); wr(2'd2, 8'd2); wr(2'd2, 8'd0);
    clr();
    ticks(10); idle(1);
    chk("R7 gate low no edge", ecnt[2], 0);
    rd16(2'd2, v);
    chk("R7 gate low count held", v, 2);
    gate[2] = 1'b1;
    ticks(4); idle(1);
    chk("R7 gate high counts", ecnt[2], 2);
    gate[2] = 1'b0;
  endtask

  task automatic t_access12();
    logic [7:0] b;
    wr(2'd3, 8'h14); wr(2'd0, 8'd3);
    clr();
    ticks(9); idle(1);
    chk("R3 low-only period", ecnt[0], 3);
    rd(2'd0, b);
    chk("R3 low-byte read", int'(b), 3);
    wr(2'd3, 8'h24); wr(2'd0, 8'd1);
    rd(2'd0, b);
    chk("R3 high-byte read", int'(b), 1);
    ticks(1);
    rd(2'd0, b);
    chk("R3 high-only low zero", int'(b), 0);
  endtask

  task automatic t_zero();
    int v;
    wr(2'd3, 8'h34); wr(2'd0, 8'd0); wr(2'd0, 8'd0);
    ticks(1);
    rd16(2'd0, v);
    chk("R5 zero is 65536", v, 16'hFFFF);
  endtask

  task automatic t_lohi();
    int v;
    wr(2'd3, 8'h34); wr(2'd0, 8'd10); wr(2'd0, 8'd0);
    ticks(6);
    rd16(2'd0, v);
    chk("R6 running count", v, 4);
    wr(2'd0, 8'd10);
    ticks(1);
    rd16(2'd0, v);
    chk("R4 first byte keeps running", v, 3);
    wr(2'd0, 8'd0);
    rd16(2'd0, v);
    chk("R6 restart on commit", v, 10);
    clr();
    ticks(9); idle(1);
    chk("R6 full period after restart", ecnt[0], 0);
    ticks(1); idle(1);
    chk("R6 edge at new period", ecnt[0], 1);
  endtask

  task automatic t_latch();
    int v;
    wr(2'd3, 8'h74); wr(2'd1, 8'd100); wr(2'd1, 8'd0);
    wr(2'd3, 8'h4E);
    ticks(10);
    rd16(2'd1, v);
    chk("R12 latched value", v, 100);
    rd16(2'd1, v);
    chk("R12 live after latch read", v, 90);
    chk("R12 mode kept", int'(out[1]), 1);
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode2();
    t_mode3();
    t_oneshot(0);
    t_oneshot(4);
    t_oneshot(5);
    t_mode1();
    t_gate();
    t_access12();
    t_zero();
    t_lohi();
    t_latch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule